// File: doc/BRIEF.md
# Segment ID Scrambler

This unit turns a context number and a 64-bit effective address into a scrambled virtual segment identifier. It builds a proto-identifier by placing the context above the effective segment number taken from the address. It then multiplies that value by the fixed prime 12538073 and reduces the product modulo 2^n-1. No divider is used. The product's high part is folded onto its low part, and an end-around carry corrects the sum. Two segment modes are supported: 256 MB segments use n = 37 and 1 TB segments use n = 25.

A kernel-mode request ignores the supplied context. The context is derived from the top address nibble instead, so regions 0xC through 0xF use the four highest context numbers. An address whose bits below the region nibble reach the page table range is a bad address. It always returns identifier zero, which is reserved for that purpose.

Requests enter with a valid strobe, one per cycle, and leave three cycles later in the same order. The multiply, the fold and the correction each take one pipeline stage.

Top module: `segscr_top`

## Requirements
- R1: In 256 MB mode (`in_seg_1t`=0) the proto-identifier is the 19-bit context followed by address bits [45:28]. The result is (proto × 12538073) mod (2^37-1).
- R2: In 1 TB mode (`in_seg_1t`=1) the proto-identifier is the context followed by address bits [45:40]. The result is (proto × 12538073) mod (2^25-1), and bits [36:25] of the output are zero.
- R3: Every result lies in 0 to 2^n-2. A proto-identifier of all ones (2^n-1) yields zero.
- R4: If any of address bits [59:46] is set, the address is out of range and the output is zero in either mode.
- R5: With `in_kernel`=1, `in_context` is ignored. The context used is (2^19-5) + (address[63:60] - 0xC) + 1, so regions 0xC to 0xF map to contexts 0x7FFFC to 0x7FFFF.
- R6: `out_valid` rises exactly three clock edges after an accepted `in_valid`. Back-to-back requests produce back-to-back results in order, and no result appears without a request.
- R7: While `rst_n` is low, and afterwards until the first request has passed through, `out_valid` is 0.
- R8: A user request (`in_kernel`=0) carries a context of at most 2^19-5. The largest legal value is handled like any other.
- R9: In user mode the region nibble address[63:60] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_context | input | 19 | User context number |
| in_ea | input | 64 | Effective address |
| in_seg_1t | input | 1 | 0: 256 MB segment, 1: 1 TB segment |
| in_kernel | input | 1 | Derive context from the region nibble |
| out_valid | output | 1 | Result strobe |
| out_vsid | output | 37 | Scrambled segment identifier |

## Verification
A lost or stale fold bit shows up as a wrong identifier on the request that carries it, three cycles after it enters. The bench compares each output against a reference computed with a true modulo. Corrupted valid or mode state appears either as a result with no request, as a missing result, or as a 1 TB result with high bits set. The proto values at the ends of the range are driven on purpose. These are all ones, which must give zero, and a product whose fold sum lands exactly on the modulus, which exercises the end-around carry.

// File: rtl/segscr_pkg.sv
// Shared types for the segment ID scrambler.
// Assumes: segment mode is a single bit travelling with each request.
package segscr_pkg;
    typedef enum logic {
        SEG_256M = 1'b0,
        SEG_1T   = 1'b1
    } seg_mode_e;
endpackage

// File: rtl/segscr_proto.sv
// Forms the proto-identifier, the context actually used, and the bad-address flag.
// Purely combinational.
// Assumes RANGE_BITS < EA_W - REGION_W and that ESID fields lie below RANGE_BITS.
module segscr_proto
    import segscr_pkg::*;
#(
    parameter int CTX_W       = 19,
    parameter int ESID_S_W    = 18,
    parameter int ESID_L_W    = 6,
    parameter int SHIFT_S     = 28,
    parameter int SHIFT_L     = 40,
    parameter int EA_W        = 64,
    parameter int REGION_W    = 4,
    parameter int RANGE_BITS  = 46,
    parameter int KERN_FIRST  = 12,
    localparam int N_S        = CTX_W + ESID_S_W
) (
    input  logic [CTX_W-1:0] ctx_in,
    input  logic [EA_W-1:0]  ea,
    input  seg_mode_e        mode,
    input  logic             kernel,
    output logic [CTX_W-1:0] ctx_sel,
    output logic [N_S-1:0]   proto,
    output logic             bad
);
    localparam int MAX_USER = (1 << CTX_W) - 5;

    logic [REGION_W-1:0] region;
    logic [ESID_S_W-1:0] esid_s;
    logic [ESID_L_W-1:0] esid_l;

    assign region = ea[EA_W-1 -: REGION_W];
    assign esid_s = ea[SHIFT_S +: ESID_S_W];
    assign esid_l = ea[SHIFT_L +: ESID_L_W];

    // Pick the user context or the one derived from the region nibble.
    always_comb begin
        if (kernel)
            ctx_sel = CTX_W'(MAX_USER + 1) + CTX_W'(region) - CTX_W'(KERN_FIRST);
        else
            ctx_sel = ctx_in;
    end

    // Place the context above the segment number for the chosen mode.
    always_comb begin
        if (mode == SEG_1T)
            proto = N_S'({ctx_sel, esid_l});
        else
            proto = {ctx_sel, esid_s};
    end

    // Any address bit between the range limit and the region nibble marks a bad address.
    assign bad = |ea[EA_W-REGION_W-1:RANGE_BITS];
endmodule

// File: rtl/segscr_mul.sv
// Stage 1: registers proto × multiplier, with valid, mode and bad flag.
// Assumes the product fits PROD_W = N_S + MULT_W bits.
module segscr_mul
    import segscr_pkg::*;
#(
    parameter int          N_S    = 37,
    parameter int          N_L    = 25,
    parameter int          MULT_W = 24,
    parameter logic [23:0] MULT   = 24'd12538073,
    localparam int         PROD_W = N_S + MULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  seg_mode_e         mode_in,
    input  logic              bad_in,
    input  logic [N_S-1:0]    proto_in,
    output logic              v_q,
    output seg_mode_e         mode_q,
    output logic              bad_q,
    output logic [PROD_W-1:0] prod_q
);
    logic [PROD_W-1:0] prod_d;

    // Full-width product of proto and the fixed prime.
    assign prod_d = PROD_W'(proto_in) * PROD_W'(MULT);

    // Valid register with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // Data registers, loaded with each request.
    always_ff @(posedge clk) begin
        if (v_in) begin
            prod_q <= prod_d;
            mode_q <= mode_in;
            bad_q  <= bad_in;
        end
    end

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_q == $past(v_in)));

    p_prod_width_1t_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && mode_q == SEG_1T) |-> (prod_q[PROD_W-1:N_L+MULT_W] == '0));
endmodule

// File: rtl/segscr_fold.sv
// Stage 2: adds the product's high part to its low n bits, with n chosen by mode.
// Assumes the high part is at most MULT_W bits wide, so the sum fits N_S+1 bits.
module segscr_fold
    import segscr_pkg::*;
#(
    parameter int  N_S    = 37,
    parameter int  N_L    = 25,
    parameter int  MULT_W = 24,
    localparam int PROD_W = N_S + MULT_W,
    localparam int X_W    = N_S + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  seg_mode_e         mode_in,
    input  logic              bad_in,
    input  logic [PROD_W-1:0] prod_in,
    output logic              v_q,
    output seg_mode_e         mode_q,
    output logic              bad_q,
    output logic [X_W-1:0]    x_q
);
    localparam logic [N_S-1:0] MASK_L = {{(N_S-N_L){1'b0}}, {N_L{1'b1}}};
    localparam logic [X_W-1:0] X_MAX_S = X_W'({N_S{1'b1}}) + X_W'({MULT_W{1'b1}});
    localparam logic [X_W-1:0] X_MAX_L = X_W'(MASK_L) + X_W'({MULT_W{1'b1}});

    logic [N_S-1:0] lo;
    logic [X_W-1:0] x_d;

    // Low n bits of the product for the active mode.
    assign lo = (mode_in == SEG_1T) ? (prod_in[N_S-1:0] & MASK_L) : prod_in[N_S-1:0];

    // High part shifted down by n and added to the low part.
    always_comb begin
        if (mode_in == SEG_1T)
            x_d = X_W'(prod_in[PROD_W-1:N_L]) + X_W'(lo);
        else
            x_d = X_W'(prod_in[PROD_W-1:N_S]) + X_W'(lo);
    end

    // Valid register with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // Data registers.
    always_ff @(posedge clk) begin
        if (v_in) begin
            x_q    <= x_d;
            mode_q <= mode_in;
            bad_q  <= bad_in;
        end
    end

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_q == $past(v_in)));

    p_fold_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (x_q <= ((mode_q == SEG_1T) ? X_MAX_L : X_MAX_S)));
endmodule

// File: rtl/segscr_fix.sv
// Stage 3: end-around correction. result = (x + ((x+1) >> n)) mod 2^n.
// A bad address is forced to zero.
// Assumes x < 2^(n+1) - 1, so (x+1) >> n is a single bit.
module segscr_fix
    import segscr_pkg::*;
#(
    parameter int  N_S = 37,
    parameter int  N_L = 25,
    localparam int X_W = N_S + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           v_in,
    input  seg_mode_e      mode_in,
    input  logic           bad_in,
    input  logic [X_W-1:0] x_in,
    output logic           v_q,
    output logic [N_S-1:0] res_q
);
    localparam logic [N_S-1:0] MASK_S = {N_S{1'b1}};
    localparam logic [N_S-1:0] MASK_L = {{(N_S-N_L){1'b0}}, {N_L{1'b1}}};

    logic [X_W-1:0] xp1;
    logic           carry;
    logic [X_W-1:0] sum;
    logic [N_S-1:0] res_d;
    seg_mode_e      mode_q;

    assign xp1   = x_in + X_W'(1);
    assign carry = (mode_in == SEG_1T) ? xp1[N_L] : xp1[N_S];
    assign sum   = x_in + X_W'(carry);

    // Mask to n bits, or zero for a bad address.
    always_comb begin
        if (bad_in)
            res_d = '0;
        else
            res_d = sum[N_S-1:0] & ((mode_in == SEG_1T) ? MASK_L : MASK_S);
    end

    // Valid register with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // Result and mode registers.
    always_ff @(posedge clk) begin
        if (v_in) begin
            res_q  <= res_d;
            mode_q <= mode_in;
        end
    end

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_q == $past(v_in)));

    p_bad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && bad_in) |=> (res_q == '0));

    p_res_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (res_q != ((mode_q == SEG_1T) ? MASK_L : MASK_S)));

    p_high_clear_1t_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && mode_q == SEG_1T) |-> ((res_q & ~MASK_L) == '0));
endmodule

// File: rtl/segscr_top.sv
// Segment ID scrambler: proto formation, multiply, fold and correction.
// Latency is three cycles; a new request may enter every cycle.
// Assumes user contexts stay at or below 2^CTX_W - 5.
module segscr_top
    import segscr_pkg::*;
#(
    parameter int          CTX_W      = 19,
    parameter int          ESID_S_W   = 18,
    parameter int          ESID_L_W   = 6,
    parameter int          SHIFT_S    = 28,
    parameter int          SHIFT_L    = 40,
    parameter int          EA_W       = 64,
    parameter int          REGION_W   = 4,
    parameter int          RANGE_BITS = 46,
    parameter int          KERN_FIRST = 12,
    parameter int          MULT_W     = 24,
    parameter logic [23:0] MULT       = 24'd12538073,
    localparam int         N_S        = CTX_W + ESID_S_W,
    localparam int         N_L        = CTX_W + ESID_L_W,
    localparam int         PROD_W     = N_S + MULT_W,
    localparam int         X_W        = N_S + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [CTX_W-1:0] in_context,
    input  logic [EA_W-1:0]  in_ea,
    input  logic             in_seg_1t,
    input  logic             in_kernel,
    output logic             out_valid,
    output logic [N_S-1:0]   out_vsid
);
    localparam logic [CTX_W-1:0] MAX_USER = CTX_W'((1 << CTX_W) - 5);

    seg_mode_e         mode_in;
    logic [CTX_W-1:0]  ctx_sel;
    logic [N_S-1:0]    proto;
    logic              bad;

    logic              v1, bad1;
    seg_mode_e         mode1;
    logic [PROD_W-1:0] prod1;

    logic              v2, bad2;
    seg_mode_e         mode2;
    logic [X_W-1:0]    x2;

    assign mode_in = seg_mode_e'(in_seg_1t);

    segscr_proto #(
        .CTX_W(CTX_W), .ESID_S_W(ESID_S_W), .ESID_L_W(ESID_L_W),
        .SHIFT_S(SHIFT_S), .SHIFT_L(SHIFT_L), .EA_W(EA_W),
        .REGION_W(REGION_W), .RANGE_BITS(RANGE_BITS), .KERN_FIRST(KERN_FIRST)
    ) u_proto (
        .ctx_in(in_context), .ea(in_ea), .mode(mode_in), .kernel(in_kernel),
        .ctx_sel(ctx_sel), .proto(proto), .bad(bad)
    );

    segscr_mul #(.N_S(N_S), .N_L(N_L), .MULT_W(MULT_W), .MULT(MULT)) u_mul (
        .clk(clk), .rst_n(rst_n), .v_in(in_valid), .mode_in(mode_in),
        .bad_in(bad), .proto_in(proto),
        .v_q(v1), .mode_q(mode1), .bad_q(bad1), .prod_q(prod1)
    );

    segscr_fold #(.N_S(N_S), .N_L(N_L), .MULT_W(MULT_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .mode_in(mode1),
        .bad_in(bad1), .prod_in(prod1),
        .v_q(v2), .mode_q(mode2), .bad_q(bad2), .x_q(x2)
    );

    segscr_fix #(.N_S(N_S), .N_L(N_L)) u_fix (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .mode_in(mode2),
        .bad_in(bad2), .x_in(x2),
        .v_q(out_valid), .res_q(out_vsid)
    );

    p_user_ctx_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kernel) |-> (in_context <= MAX_USER));

    p_kernel_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kernel && in_ea[EA_W-1:EA_W-2] == 2'b11)
        |-> (ctx_sel == {{(CTX_W-2){1'b1}}, in_ea[EA_W-3:EA_W-4]}));
endmodule

// File: tb/sim_segscr_top.sv
module sim_segscr_top;
    localparam int CLK_PERIOD = 10;
    localparam longint unsigned MULTV = 64'd12538073;

    typedef struct {
        logic [36:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [18:0] in_context = '0;
    logic [63:0] in_ea = '0;
    logic        in_seg_1t = 1'b0;
    logic        in_kernel = 1'b0;
    logic        out_valid;
    logic [36:0] out_vsid;

    int    total = 0;
    int    bad_cnt = 0;
    item_t sb[$];

    segscr_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_context(in_context),
        .in_ea(in_ea), .in_seg_1t(in_seg_1t), .in_kernel(in_kernel),
        .out_valid(out_valid), .out_vsid(out_vsid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference from the requirements: true modulo, no folding.
    function automatic logic [36:0] ref_vsid(input logic [18:0] ctx, input logic [63:0] ea,
                                             input logic seg1t, input logic kern);
        longint unsigned c, proto, modv;
        if (ea[59:46] != 0) return '0;                       // R4
        if (kern) c = (longint'(524283) + longint'(ea[63:60]) - 12 + 1) & 64'h7FFFF; // R5
        else      c = ctx;
        if (seg1t) begin
            proto = (c << 6) | ea[45:40];
            modv  = (64'd1 << 25) - 1;
        end else begin
            proto = (c << 18) | ea[45:28];
            modv  = (64'd1 << 37) - 1;
        end
        return 37'((proto * MULTV) % modv);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [36:0] act,
                         input logic [36:0] exp);
        total++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one request in the next cycle and queues its expected result.
    task automatic send(input logic [18:0] ctx, input logic [63:0] ea,
                        input logic seg1t, input logic kern, input string tag);
        item_t it;
        @(posedge clk); #1;
        in_valid   = 1'b1;
        in_context = ctx;
        in_ea      = ea;
        in_seg_1t  = seg1t;
        in_kernel  = kern;
        it.exp = ref_vsid(ctx, ea, seg1t, kern);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid   = 1'b0;
            in_context = 19'h5A5A5;
            in_ea      = 64'hFFFF_FFFF_FFFF_FFFF;
        end
    endtask

    // Monitor: pops and compares each result; unexpected results count as failures.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6 unexpected result", out_vsid, '0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_vsid === it.exp, it.tag, out_vsid, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 50000);
        bad_cnt++;
        total++;
        $display("FAIL R6 watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad_cnt);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R7 valid low in reset", 37'(out_valid), '0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R7 valid low after reset", 37'(out_valid), '0);

        // R1: 256 MB user requests, back to back (R6).
        for (int i = 0; i < 40; i++)
            send(19'($urandom % 524284), {4'h0, 14'h0, 46'($urandom) << 20 | 46'($urandom)},
                 1'b0, 1'b0, "R1 256M user");
        idle(2);
        // R2: 1 TB user requests.
        for (int i = 0; i < 40; i++)
            send(19'($urandom % 524284), {4'h0, 14'h0, 6'($urandom), 40'($urandom)},
                 1'b1, 1'b0, "R2 1T user");
        idle(1);
        // R3: proto all ones gives zero, both modes.
        send(19'h0, 64'hF000_3FFF_F000_0000, 1'b0, 1'b1, "R3 all-ones 256M");
        send(19'h0, 64'hF000_3F00_0000_0000, 1'b1, 1'b1, "R3 all-ones 1T");
        send(19'h7FFFB, 64'h0000_3FFF_FFFF_FFFF, 1'b0, 1'b0, "R3 top user 256M");
        // R4: out-of-range bits give zero.
        send(19'h12345, 64'h0000_4000_0000_0000, 1'b0, 1'b0, "R4 bit46 256M");
        send(19'h12345, 64'h0800_0000_0000_0000, 1'b1, 1'b0, "R4 bit59 1T");
        send(19'h0, 64'hC000_8000_1000_0000, 1'b0, 1'b1, "R4 kernel bad");
        // R5: kernel regions with junk in_context.
        for (int r = 12; r < 16; r++) begin
            send(19'h55555, {4'(r), 14'h0, 46'h1234_5678_9ABC}, 1'b0, 1'b1, "R5 kernel 256M");
            send(19'h2AAAA, {4'(r), 14'h0, 46'h2F00_1234_5678}, 1'b1, 1'b1, "R5 kernel 1T");
        end
        // R8: largest legal user context.
        send(19'h7FFFB, 64'h0000_1234_5000_0000, 1'b0, 1'b0, "R8 max user 256M");
        send(19'h7FFFB, 64'h0000_2A00_0000_0000, 1'b1, 1'b0, "R8 max user 1T");
        // R9: region nibble ignored in user mode (expected equals nibble-zero value).
        send(19'h0ABCD, 64'h5000_1111_2000_0000, 1'b0, 1'b0, "R9 nibble 5");
        send(19'h0ABCD, 64'h0000_1111_2000_0000, 1'b0, 1'b0, "R9 nibble 0");
        send(19'h0ABCD, 64'hB000_1111_2000_0000, 1'b1, 1'b0, "R9 nibble B 1T");
        // R6: isolated requests with gaps.
        send(19'h00001, 64'h0000_0000_1000_0000, 1'b0, 1'b0, "R6 gap a");
        idle(3);
        send(19'h00002, 64'h0000_0100_0000_0000, 1'b1, 1'b0, "R6 gap b");
        idle(6);
        @(negedge clk);
        check(sb.size() == 0, "R6 all results returned", 37'(sb.size()), '0);
        check(out_valid === 1'b0, "R6 no extra result", 37'(out_valid), '0);
        $display("test done: total=%0d bad=%0d", total, bad_cnt);
        $finish;
    end
endmodule